// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Datapath

This block moves a byte stream between a 16-bit peripheral and a byte-addressed memory port. A request carries an address, a byte count, a direction and a flag that turns byte swapping off. The memory address is the request address ORed with a base value held in the block. The base value is loaded separately and sampled when a request is accepted.

When swapping is on, the block treats the stream as halfwords. It forces the address even, trims an odd count down by one, and exchanges the two bytes of every halfword on its way through. This applies in both directions. Swapped transfers toward memory are cut into commands of at most 64 bytes, with the address stepping forward by each command's length. When swapping is off, bytes, address and count pass through untouched, and a single memory command covers the whole request.

Every port uses a valid/ready handshake. A one-cycle done pulse closes each request.

Top module: `hwswap_dma`

## Requirements
- R1: The memory command address equals the request address bitwise ORed with the base value last loaded through `base_we`/`base_wdata` (reset value 0).
- R2: With `req_noswap`=1, bytes reach the sink in arrival order and unchanged, and the full request length is used, odd counts included.
- R3: With `req_noswap`=0, address bit 0 is cleared after the OR, and the length is rounded down to even (bit 0 cleared).
- R4: With `req_noswap`=0 and `req_to_mem`=1, the peripheral bytes p[0],p[1],p[2],... are written to memory as p[1],p[0],p[3],p[2],... at consecutive addresses starting from the command address.
- R5: With `req_noswap`=0 and `req_to_mem`=0, memory bytes m[a],m[a+1],... are delivered to the peripheral as m[a+1],m[a],m[a+3],m[a+2],...
- R6: A swapped write is issued as commands of min(64, remaining) bytes. Each command's address is the previous address plus the previous length, and the lengths sum to the effective length.
- R7: A read, and a write with `req_noswap`=1, is issued as exactly one memory command covering the effective length.
- R8: A request whose effective length is zero issues no memory command and moves no data. `done` is high in the cycle after the request handshake.
- R9: `done` is high for exactly one cycle, in the cycle after the last sink byte handshake. `req_ready` is high only while no request is in progress.
- R10: A raised `mcmd_valid` or `mwr_valid` stays raised, with its address, length or data unchanged, until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load the base value |
| base_wdata | input | ADDR_W | New base value |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | ADDR_W | Request address |
| req_len | input | LEN_W | Request byte count |
| req_to_mem | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_noswap | input | 1 | 1: pass bytes, address and count through unchanged |
| pin_valid | input | 1 | Peripheral byte offered (write direction) |
| pin_ready | output | 1 | Peripheral byte taken |
| pin_data | input | 8 | Peripheral byte |
| pout_valid | output | 1 | Byte for the peripheral (read direction) |
| pout_ready | input | 1 | Peripheral takes the byte |
| pout_data | output | 8 | Byte for the peripheral |
| mcmd_valid | output | 1 | Memory command offered |
| mcmd_ready | input | 1 | Memory command taken |
| mcmd_addr | output | ADDR_W | Command start address |
| mcmd_len | output | LEN_W | Command byte count |
| mcmd_write | output | 1 | Command direction, 1 = write |
| mwr_valid | output | 1 | Write byte offered to memory |
| mwr_ready | input | 1 | Memory takes the write byte |
| mwr_data | output | 8 | Write byte |
| mrd_valid | input | 1 | Read byte offered by memory |
| mrd_ready | output | 1 | Read byte taken |
| mrd_data | input | 8 | Read byte |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The hardest case to reach is a swapped write that spans several 64-byte commands while the sink stalls in the middle of a halfword. The second byte of the pair has to come out before the first, and the next command must not be issued until the last byte of the current one has been handshaken. The stimulus sweeps lengths on both sides of 64 and 128, including odd ones that get trimmed, in both directions and both swap modes. Every other request applies periodic gaps to each ready and source valid, so stalls fall at different offsets within the pairs and the bursts.

// File: rtl/hwswap_dma.sv
module hwswap_dma #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int BURST  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_to_mem,
  input  logic              req_noswap,
  input  logic              pin_valid,
  output logic              pin_ready,
  input  logic [7:0]        pin_data,
  output logic              pout_valid,
  input  logic              pout_ready,
  output logic [7:0]        pout_data,
  output logic              mcmd_valid,
  input  logic              mcmd_ready,
  output logic [ADDR_W-1:0] mcmd_addr,
  output logic [LEN_W-1:0]  mcmd_len,
  output logic              mcmd_write,
  output logic              mwr_valid,
  input  logic              mwr_ready,
  output logic [7:0]        mwr_data,
  input  logic              mrd_valid,
  output logic              mrd_ready,
  input  logic [7:0]        mrd_data,
  output logic              done
);

  localparam logic [LEN_W-1:0] BURST_L = LEN_W'(BURST);

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_DATA, ST_DONE} st_t;

  st_t               state;
  logic [ADDR_W-1:0] base_q, cur_addr;
  logic [LEN_W-1:0]  remain, seg_left;
  logic              wr_q, swp_q;
  logic [7:0]        hold0, hold1;
  logic [1:0]        hcnt;
  logic              ocnt;

  logic [ADDR_W-1:0] or_addr, eff_addr;
  logic [LEN_W-1:0]  eff_len, seg;
  logic              full, in_data, src_valid, snk_ready, src_fire, snk_fire;
  logic [7:0]        src_byte, out_byte;

  assign or_addr  = req_addr | base_q;
  assign eff_addr = {or_addr[ADDR_W-1:1], or_addr[0] & req_noswap};
  assign eff_len  = {req_len[LEN_W-1:1], req_len[0] & req_noswap};
  assign seg      = (wr_q && swp_q && remain > BURST_L) ? BURST_L : remain;

  assign in_data   = (state == ST_DATA);
  assign full      = swp_q ? (hcnt == 2'd2) : (hcnt == 2'd1);
  assign src_valid = wr_q ? pin_valid : mrd_valid;
  assign src_byte  = wr_q ? pin_data : mrd_data;
  assign snk_ready = wr_q ? mwr_ready : pout_ready;
  assign src_fire  = in_data && !full && src_valid;
  assign snk_fire  = in_data && full && snk_ready;
  assign out_byte  = (swp_q && !ocnt) ? hold1 : hold0;

  assign req_ready  = (state == ST_IDLE);
  assign done       = (state == ST_DONE);
  assign mcmd_valid = (state == ST_CMD);
  assign mcmd_addr  = cur_addr;
  assign mcmd_len   = seg;
  assign mcmd_write = wr_q;
  assign pin_ready  = in_data && !full && wr_q;
  assign mrd_ready  = in_data && !full && !wr_q;
  assign mwr_valid  = in_data && full && wr_q;
  assign pout_valid = in_data && full && !wr_q;
  assign mwr_data   = out_byte;
  assign pout_data  = out_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      seg_left <= '0;
      wr_q     <= 1'b0;
      swp_q    <= 1'b0;
      hold0    <= '0;
      hold1    <= '0;
      hcnt     <= '0;
      ocnt     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          cur_addr <= eff_addr;
          remain   <= eff_len;
          wr_q     <= req_to_mem;
          swp_q    <= !req_noswap;
          state    <= (eff_len == '0) ? ST_DONE : ST_CMD;
        end
        ST_CMD: if (mcmd_ready) begin
          seg_left <= seg;
          remain   <= remain - seg;
          cur_addr <= cur_addr + ADDR_W'(seg);
          hcnt     <= '0;
          ocnt     <= 1'b0;
          state    <= ST_DATA;
        end
        ST_DATA: begin
          if (src_fire) begin
            if (hcnt == 2'd0) hold0 <= src_byte;
            else hold1 <= src_byte;
            hcnt <= hcnt + 2'd1;
          end
          if (snk_fire) begin
            seg_left <= seg_left - 1'b1;
            if (!swp_q || ocnt) begin
              hcnt <= '0;
              ocnt <= 1'b0;
            end else begin
              ocnt <= 1'b1;
            end
            if (seg_left == LEN_W'(1)) state <= (remain == '0) ? ST_DONE : ST_CMD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_burst_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mcmd_valid && mcmd_write && swp_q |-> mcmd_len <= BURST_L && mcmd_len != '0);

  assert_even_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mcmd_valid && swp_q |-> !mcmd_addr[0] && !mcmd_len[0]);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mcmd_valid && !mcmd_ready |=> mcmd_valid && $stable(mcmd_addr) && $stable(mcmd_len));

  assert_wdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mwr_valid && !mwr_ready |=> mwr_valid && $stable(mwr_data));

endmodule

// File: tb/sim_hwswap_dma.sv
module sim_hwswap_dma;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_we = 1'b0;
  logic [AW-1:0] base_wdata = '0;
  logic req_valid = 1'b0, req_to_mem = 1'b0, req_noswap = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic req_ready, pin_ready, pout_valid, mcmd_valid, mcmd_write, mwr_valid, mrd_ready, done;
  logic pin_valid = 1'b0, pout_ready = 1'b0, mcmd_ready = 1'b0, mwr_ready = 1'b0, mrd_valid = 1'b0;
  logic [7:0] pin_data = '0, mrd_data = '0, pout_data, mwr_data;
  logic [AW-1:0] mcmd_addr;
  logic [LW-1:0] mcmd_len;

  hwswap_dma u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  int pidx, plen, nw, no, ncmd, ndone, done_cyc, last_cyc, acc_cyc, seed;
  int rd_cnt, rd_len;
  logic rd_act, accepted, bp;
  logic [AW-1:0] rd_base, wbase, woff;
  logic [AW-1:0] waddr [256];
  logic [7:0] wdat [256], odat [256];
  logic [AW-1:0] cmd_a [16];
  int cmd_l [16];

  function automatic logic [7:0] pbyte(int i, int s);
    return 8'(i * 5 + 17 + s);
  endfunction

  function automatic logic [7:0] memf(logic [AW-1:0] a);
    return 8'(a[7:0] * 3) ^ a[15:8];
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      mcmd_ready = !bp || (cyc % 3 != 0);
      mwr_ready  = !bp || (cyc % 3 != 1);
      pout_ready = !bp || (cyc % 5 != 2);
      pin_valid  = (pidx < plen) && (!bp || cyc % 4 != 3);
      pin_data   = pbyte(pidx, seed);
      mrd_valid  = rd_act && (rd_cnt < rd_len) && (!bp || cyc % 4 != 0);
      mrd_data   = memf(rd_base + AW'(rd_cnt));
      if (req_valid && req_ready) begin accepted = 1'b1; acc_cyc = cyc; end
      if (pin_valid && pin_ready) pidx++;
      if (mrd_valid && mrd_ready) rd_cnt++;
      if (mcmd_valid && mcmd_ready) begin
        if (ncmd < 16) begin cmd_a[ncmd] = mcmd_addr; cmd_l[ncmd] = int'(mcmd_len); end
        ncmd++;
        if (mcmd_write) begin wbase = mcmd_addr; woff = '0; end
        else begin rd_act = 1'b1; rd_base = mcmd_addr; rd_cnt = 0; rd_len = int'(mcmd_len); end
      end
      if (mwr_valid && mwr_ready) begin
        if (nw < 256) begin waddr[nw] = wbase + woff; wdat[nw] = mwr_data; end
        nw++; woff++; last_cyc = cyc;
      end
      if (pout_valid && pout_ready) begin
        if (no < 256) odat[no] = pout_data;
        no++; last_cyc = cyc;
      end
      if (done) begin
        if (ndone == 0) done_cyc = cyc;
        ndone++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic set_base(input logic [AW-1:0] b);
    @(posedge clk); #2;
    base_we = 1'b1; base_wdata = b;
    @(posedge clk); #2;
    base_we = 1'b0;
  endtask

  task automatic run_req(input logic wr, input logic ns, input logic [AW-1:0] a,
                         input int len, input logic bpv, input logic [AW-1:0] base);
    int n, exp_cmds, bad, first_bad_act, first_bad_exp, waited;
    logic [AW-1:0] ea;
    n  = ns ? len : (len & ~1);
    ea = (a | base) & (ns ? {AW{1'b1}} : {{(AW-1){1'b1}}, 1'b0});
    @(posedge clk); #2;
    pidx = 0; plen = wr ? n : 0; nw = 0; no = 0; ncmd = 0; ndone = 0;
    done_cyc = -1; last_cyc = -1; acc_cyc = -1; accepted = 1'b0; rd_act = 1'b0;
    rd_cnt = 0; rd_len = 0; bp = bpv; seed = len + int'(a[3:0]);
    req_valid = 1'b1; req_addr = a; req_len = LW'(len); req_to_mem = wr; req_noswap = ns;
    waited = 0;
    while (!accepted && waited < 100) begin @(posedge clk); #2; waited++; end
    req_valid = 1'b0;
    waited = 0;
    while (ndone == 0 && waited < 3000) begin @(posedge clk); #2; waited++; end
    repeat (3) @(posedge clk);
    #2;
    // R8 R9: single done pulse at the right cycle
    check(ndone == 1, "R9 done pulse count", ndone, 1);
    check(done_cyc == ((n == 0) ? acc_cyc + 1 : last_cyc + 1), "R8/R9 done cycle", done_cyc,
          (n == 0) ? acc_cyc + 1 : last_cyc + 1);
    exp_cmds = (n == 0) ? 0 : ((wr && !ns) ? (n + 63) / 64 : 1);
    check(ncmd == exp_cmds, wr && !ns ? "R6 command count" : "R7/R8 command count", ncmd, exp_cmds);
    bad = 0; first_bad_act = 0; first_bad_exp = 0;
    for (int k = 0; k < exp_cmds && k < ncmd; k++) begin
      int el;
      el = (wr && !ns) ? ((n - 64 * k > 64) ? 64 : n - 64 * k) : n;
      if (cmd_a[k] != ea + AW'(64 * k) || cmd_l[k] != el) begin
        if (bad == 0) begin first_bad_act = int'(cmd_a[k]); first_bad_exp = int'(ea + AW'(64 * k)); end
        bad++;
      end
    end
    check(bad == 0, "R1/R3/R6 command address and length", first_bad_act, first_bad_exp);
    check((wr ? nw : no) == n, "R2/R3 byte count", wr ? nw : no, n);
    bad = 0;
    for (int i = 0; i < n && i < 256; i++) begin
      int j;
      logic [7:0] eb;
      j = ns ? i : (i ^ 1);
      if (wr) begin
        eb = pbyte(j, seed);
        if (wdat[i] != eb || waddr[i] != ea + AW'(i)) begin
          if (bad == 0) begin first_bad_act = int'(wdat[i]); first_bad_exp = int'(eb); end
          bad++;
        end
      end else begin
        eb = memf(ea + AW'(j));
        if (odat[i] != eb) begin
          if (bad == 0) begin first_bad_act = int'(odat[i]); first_bad_exp = int'(eb); end
          bad++;
        end
      end
    end
    check(bad == 0, ns ? "R2 passthrough data" : (wr ? "R4 swapped write data" : "R5 swapped read data"),
          first_bad_act, first_bad_exp);
    check(req_ready == 1'b1 && done == 1'b0, "R9 idle after request", int'(req_ready), 1);
  endtask

  int lens [14] = '{0, 1, 2, 3, 5, 63, 64, 65, 66, 127, 128, 130, 200, 255};

  initial begin
    bp = 1'b0; pidx = 0; plen = 0; rd_act = 1'b0; rd_cnt = 0; rd_len = 0; seed = 0;
    nw = 0; no = 0; ncmd = 0; ndone = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    check(req_ready == 1'b1, "R9 reset req_ready", int'(req_ready), 1);
    check(done == 1'b0 && mcmd_valid == 1'b0, "R9 reset done/mcmd", int'(done) + int'(mcmd_valid), 0);
    check(mwr_valid == 1'b0 && pout_valid == 1'b0, "R10 reset sinks idle", int'(mwr_valid) + int'(pout_valid), 0);
    run_req(1'b1, 1'b1, 16'h0013, 4, 1'b0, 16'h0000);  // R1 base zero after reset
    for (int wr = 0; wr < 2; wr++) begin
      for (int ns = 0; ns < 2; ns++) begin
        logic [AW-1:0] b;
        b = (ns == 0) ? 16'h8001 : 16'h4200;
        set_base(b);
        for (int li = 0; li < 14; li++) begin
          logic [AW-1:0] a;
          a = 16'h1235 + AW'(li * 16'h0101);
          run_req(wr[0], ns[0], a, lens[li], li[0], b);
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule